// File: doc/BRIEF.md
# Flash Command Sequencer with Unlock Bypass

This block is the command interface of a byte-wide flash memory model. A host issues write cycles (address, data, write strobe) that the block decodes into four operations: a standard byte program behind a two-write unlock, a fast program while an unlock-bypass mode is active, a whole-array erase and a sector erase. The array is a small register memory. It starts at all-ones and can be inferred as block RAM. Program and erase run with fixed latency: a program takes `PROG_CYC` cycles, and an erase visits every byte once, one per cycle.

During a sector erase the block keeps accepting further sector-erase writes inside a window of `WINDOW_CYC` cycles, and each one restarts the window. While an operation is running, reads return a status byte instead of array data: a data-polling bit, a toggling bit, an error bit and a window/erasing bit. A host polls this byte until the operation is over. Read data, whether from the array or the status byte, appears in the cycle after the read strobe. The unlock pair is AAh at address 555h and then 55h at address 2AAh. These compare only the low 11 address bits, so `ADDR_W` must be at least 11. The sector number is the top `SECT_W` address bits.

Top module: `flash_seq`

## Requirements
- R1: Four writes program one byte: AAh@555h, 55h@2AAh, A0h@555h, then the data at the target address. After `busy` falls, a read of that address returns the data.
- R2: A write that does not match the expected unlock, command or erase-confirm cycle returns the block to read mode. Nothing is changed, and later writes of a partial sequence have no effect.
- R3: AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In this mode, A0h at any address followed by address+data programs one byte, and this may be repeated.
- R4: In bypass mode every write other than A0h or 90h is ignored, including F0h and unlock or erase bytes.
- R5: In bypass mode, 90h and then 00h, at any addresses, return the block to read mode. After that, a lone A0h write does not arm a program.
- R6: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h sets every byte to FFh. No write is acted on until the erase ends.
- R7: The same first five cycles followed by 30h at a sector address start a window of `WINDOW_CYC` cycles. Each further 30h write in the window adds its sector and restarts the window. When the window expires, the selected sectors become FFh and the other sectors keep their contents.
- R8: Status bit 3 reads 0 while the sector window is counting. It reads 1 while an erase is writing the array.
- R9: Status bit 6 inverts on every status read while `busy` is high.
- R10: Status bit 7 reads the complement of bit 7 of the byte being programmed during a program, and 0 during an erase.
- R11: A program that would turn a 0 bit into a 1 leaves the byte unchanged and holds `busy` high with status bit 5 = 1. A write of F0h then returns the block to read mode.
- R12: After reset `busy` is 0, the block is in read mode, and the array reads FFh before it is first programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data / command byte |
| bus_rdata | output | 8 | Array byte or status byte, valid the cycle after the read strobe |
| busy | output | 1 | High while a program, failed program, sector window or erase is in progress |

## Verification
If the decoder has lost its place in a command sequence, the fault appears as a byte that does not change, or one that changes without cause. It is seen at the first read-back after `busy` falls, a few cycles after the last write. If the bypass state is held or dropped wrongly, the next two-write program lands or fails to land. If the window counter does not reload, bit 3 rises while the host is still adding sectors. A wrong status register shows up on the next status read, as a bit 6 that does not flip or a bit 7, 5 or 3 with the wrong value for the current operation.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_E0, S_E1, S_E2, S_PGM_D,
    S_BYP, S_BYP_D, S_BYP_X, S_PROG, S_FAIL, S_WIN, S_ERASE
  } seq_state_e;

  localparam logic [7:0] C_UNLK1 = 8'hAA;
  localparam logic [7:0] C_UNLK2 = 8'h55;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_ERS   = 8'h80;
  localparam logic [7:0] C_BULK  = 8'h10;
  localparam logic [7:0] C_SECT  = 8'h30;
  localparam logic [7:0] C_BYPX  = 8'h90;
  localparam logic [7:0] C_RST   = 8'hF0;

  localparam logic [10:0] A_UNLK1 = 11'h555;
  localparam logic [10:0] A_UNLK2 = 11'h2AA;

endpackage

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/flash_seq_window.sv
module flash_seq_window #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      cnt   <= CW'(CYC - 1);
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - CW'(1);
    end
  end

  assign expired = armed && (cnt == '0) && !restart;

  // R7: a new sector write reloads the full window
  a_r7_window_reload: assert property (@(posedge clk) disable iff (rst)
    restart |=> (armed && cnt == CW'(CYC - 1)));

  // R7: without a restart the window counts down by one per cycle
  a_r7_window_counts: assert property (@(posedge clk) disable iff (rst)
    (armed && !restart && cnt != '0) |=> (armed && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int AW       = 11,
  parameter int SW       = 2,
  parameter int PROG_CYC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    arr_rd_q,
  output logic          arr_wr_en,
  output logic [AW-1:0] arr_wr_addr,
  output logic [7:0]    arr_wr_data,
  output logic [AW-1:0] arr_rd_addr,
  input  logic          win_expired,
  output logic          win_restart,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int NSECT = 1 << SW;
  localparam int PCW   = $clog2(PROG_CYC);

  seq_state_e       state;
  logic             ret_byp;
  logic [AW-1:0]    prog_addr;
  logic [7:0]       prog_data;
  logic [PCW-1:0]   cnt;
  logic [AW-1:0]    walk;
  logic [NSECT-1:0] sect_mask;
  logic             tog;
  logic [7:0]       stat_q;
  logic             sel_stat;

  logic [10:0]   a11;
  logic          hit_u1, hit_u2, at_555, prog_last, bad_bits;
  logic [SW-1:0] sect_in, sect_walk;

  assign a11       = addr[10:0];
  assign at_555    = (a11 == A_UNLK1);
  assign hit_u1    = (wdata == C_UNLK1) && at_555;
  assign hit_u2    = (wdata == C_UNLK2) && (a11 == A_UNLK2);
  assign sect_in   = addr[AW-1 -: SW];
  assign sect_walk = walk[AW-1 -: SW];
  assign prog_last = (cnt == PCW'(PROG_CYC - 1));
  assign bad_bits  = |(prog_data & ~arr_rd_q);

  assign busy        = state inside {S_PROG, S_FAIL, S_WIN, S_ERASE};
  assign arr_rd_addr = (state == S_PROG) ? prog_addr : addr;
  assign arr_wr_en   = ((state == S_PROG) && prog_last && !bad_bits) ||
                       ((state == S_ERASE) && sect_mask[sect_walk]);
  assign arr_wr_addr = (state == S_ERASE) ? walk : prog_addr;
  assign arr_wr_data = (state == S_ERASE) ? 8'hFF : prog_data;
  assign win_restart = we && (wdata == C_SECT) && ((state == S_E2) || (state == S_WIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_READ;
      ret_byp   <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      cnt       <= '0;
      walk      <= '0;
      sect_mask <= '0;
    end else begin
      unique case (state)
        S_READ:  if (we && hit_u1) state <= S_U1;
        S_U1:    if (we) state <= hit_u2 ? S_U2 : S_READ;
        S_U2:    if (we) begin
          if      (at_555 && wdata == C_PGM) state <= S_PGM_D;
          else if (at_555 && wdata == C_BYP) state <= S_BYP;
          else if (at_555 && wdata == C_ERS) state <= S_E0;
          else                               state <= S_READ;
        end
        S_E0:    if (we) state <= hit_u1 ? S_E1 : S_READ;
        S_E1:    if (we) state <= hit_u2 ? S_E2 : S_READ;
        S_E2:    if (we) begin
          if (at_555 && wdata == C_BULK) begin
            sect_mask <= '1;
            walk      <= '0;
            state     <= S_ERASE;
          end else if (wdata == C_SECT) begin
            sect_mask          <= '0;
            sect_mask[sect_in] <= 1'b1;
            state              <= S_WIN;
          end else begin
            state <= S_READ;
          end
        end
        S_PGM_D, S_BYP_D: if (we) begin
          prog_addr <= addr;
          prog_data <= wdata;
          ret_byp   <= (state == S_BYP_D);
          cnt       <= '0;
          state     <= S_PROG;
        end
        S_BYP:   if (we) begin
          if      (wdata == C_PGM)  state <= S_BYP_D;
          else if (wdata == C_BYPX) state <= S_BYP_X;
        end
        S_BYP_X: if (we) state <= (wdata == 8'h00) ? S_READ : S_BYP;
        S_PROG: begin
          cnt <= cnt + PCW'(1);
          if (prog_last) state <= bad_bits ? S_FAIL : (ret_byp ? S_BYP : S_READ);
        end
        S_FAIL:  if (we && wdata == C_RST) state <= S_READ;
        S_WIN: begin
          if (win_restart) sect_mask[sect_in] <= 1'b1;
          if (win_expired) begin
            walk  <= '0;
            state <= S_ERASE;
          end
        end
        S_ERASE: begin
          walk <= walk + AW'(1);
          if (walk == '1) begin
            sect_mask <= '0;
            state     <= S_READ;
          end
        end
        default: state <= S_READ;
      endcase
    end
  end

  // status byte: bit7 polling, bit6 toggle, bit5 error, bit3 erasing
  always_ff @(posedge clk) begin
    if (rst) begin
      tog      <= 1'b0;
      stat_q   <= '0;
      sel_stat <= 1'b0;
    end else if (re) begin
      sel_stat <= busy;
      if (busy) begin
        tog    <= ~tog;
        stat_q <= {(state == S_PROG || state == S_FAIL) ? ~prog_data[7] : 1'b0,
                   ~tog, state == S_FAIL, 1'b0, state == S_ERASE, 3'b000};
      end
    end
  end

  assign rdata = sel_stat ? stat_q : arr_rd_q;

  // R9: consecutive status reads return opposite toggle bits
  a_r9_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (re && busy) |=> (stat_q[6] != $past(stat_q[6])));

  // R4: non-bypass commands leave bypass mode in place
  a_r4_bypass_holds: assert property (@(posedge clk) disable iff (rst)
    (state == S_BYP && we && wdata != C_PGM && wdata != C_BYPX) |=> (state == S_BYP));

  // R6: an erase runs to its last byte regardless of bus writes
  a_r6_erase_uninterrupted: assert property (@(posedge clk) disable iff (rst)
    (state == S_ERASE && walk != '1) |=> (state == S_ERASE && walk == $past(walk) + AW'(1)));

  // R11: a failed program stays failed until the reset command
  a_r11_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == S_FAIL && !(we && wdata == C_RST)) |=> (state == S_FAIL));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int SECT_W     = 2,
  parameter int WINDOW_CYC = 64,
  parameter int PROG_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              busy
);
  logic              arr_wr_en;
  logic [ADDR_W-1:0] arr_wr_addr, arr_rd_addr;
  logic [7:0]        arr_wr_data, arr_rd_q;
  logic              win_restart, win_expired;

  flash_seq_ctrl #(.AW(ADDR_W), .SW(SECT_W), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr), .wdata(bus_wdata),
    .arr_rd_q(arr_rd_q), .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr),
    .arr_wr_data(arr_wr_data), .arr_rd_addr(arr_rd_addr),
    .win_expired(win_expired), .win_restart(win_restart),
    .rdata(bus_rdata), .busy(busy)
  );

  flash_seq_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .wr_en(arr_wr_en), .wr_addr(arr_wr_addr), .wr_data(arr_wr_data),
    .rd_addr(arr_rd_addr), .rd_q(arr_rd_q)
  );

  flash_seq_window #(.CYC(WINDOW_CYC)) u_window (
    .clk(clk), .rst(rst), .restart(win_restart), .expired(win_expired)
  );
endmodule

// File: tb/tb_flash_seq.sv
`timescale 1ns/1ps
module tb_flash_seq;
  localparam int AW  = 11;
  localparam int WIN = 64;
  localparam int PGM = 8;
  localparam int NV  = 86;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_seq #(.ADDR_W(AW), .SECT_W(2), .WINDOW_CYC(WIN), .PROG_CYC(PGM)) dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .busy(busy)
  );

  // {op, addr, data, req}: op 0 write, 1 read and compare, 2 wait for idle
  localparam logic [24:0] VEC [NV] = '{
    {2'd1,11'h100,8'hFF,4'd12},                                   // R12 erased array
    {2'd0,11'h555,8'hAA,4'd1},{2'd0,11'h2AA,8'h55,4'd1},          // R1 standard program
    {2'd0,11'h555,8'hA0,4'd1},{2'd0,11'h100,8'h5A,4'd1},
    {2'd2,11'h000,8'h00,4'd1},{2'd1,11'h100,8'h5A,4'd1},
    {2'd0,11'h555,8'hAA,4'd2},{2'd0,11'h2AA,8'h55,4'd2},          // R2 bad erase confirm
    {2'd0,11'h555,8'h80,4'd2},{2'd0,11'h555,8'hAA,4'd2},
    {2'd0,11'h2AA,8'h55,4'd2},{2'd0,11'h555,8'h11,4'd2},
    {2'd1,11'h100,8'h5A,4'd2},
    {2'd0,11'h555,8'hAA,4'd2},{2'd0,11'h2AB,8'h55,4'd2},          // R2 bad unlock address
    {2'd0,11'h555,8'hA0,4'd2},{2'd0,11'h101,8'h22,4'd2},
    {2'd2,11'h000,8'h00,4'd2},{2'd1,11'h101,8'hFF,4'd2},
    {2'd0,11'h555,8'hAA,4'd3},{2'd0,11'h2AA,8'h55,4'd3},          // R3 bypass entry
    {2'd0,11'h555,8'h20,4'd3},
    {2'd0,11'h000,8'hA0,4'd3},{2'd0,11'h200,8'h33,4'd3},
    {2'd2,11'h000,8'h00,4'd3},{2'd1,11'h200,8'h33,4'd3},
    {2'd0,11'h7FF,8'hA0,4'd3},{2'd0,11'h201,8'h44,4'd3},
    {2'd2,11'h000,8'h00,4'd3},{2'd1,11'h201,8'h44,4'd3},
    {2'd0,11'h555,8'hF0,4'd4},{2'd0,11'h555,8'hAA,4'd4},          // R4 ignored in bypass
    {2'd0,11'h2AA,8'h55,4'd4},{2'd0,11'h555,8'h80,4'd4},
    {2'd0,11'h000,8'hA0,4'd4},{2'd0,11'h202,8'h77,4'd4},
    {2'd2,11'h000,8'h00,4'd4},{2'd1,11'h202,8'h77,4'd4},
    {2'd0,11'h123,8'h90,4'd5},{2'd0,11'h456,8'h00,4'd5},          // R5 bypass exit
    {2'd0,11'h000,8'hA0,4'd5},{2'd0,11'h204,8'h55,4'd5},
    {2'd2,11'h000,8'h00,4'd5},{2'd1,11'h204,8'hFF,4'd5},
    {2'd0,11'h555,8'hAA,4'd7},{2'd0,11'h2AA,8'h55,4'd7},          // R7 fill sectors 0,2,3
    {2'd0,11'h555,8'hA0,4'd7},{2'd0,11'h000,8'h12,4'd7},{2'd2,11'h000,8'h00,4'd7},
    {2'd0,11'h555,8'hAA,4'd7},{2'd0,11'h2AA,8'h55,4'd7},
    {2'd0,11'h555,8'hA0,4'd7},{2'd0,11'h400,8'h56,4'd7},{2'd2,11'h000,8'h00,4'd7},
    {2'd0,11'h555,8'hAA,4'd7},{2'd0,11'h2AA,8'h55,4'd7},
    {2'd0,11'h555,8'hA0,4'd7},{2'd0,11'h600,8'h78,4'd7},{2'd2,11'h000,8'h00,4'd7},
    {2'd0,11'h555,8'hAA,4'd7},{2'd0,11'h2AA,8'h55,4'd7},          // R7 erase sectors 0 and 2
    {2'd0,11'h555,8'h80,4'd7},{2'd0,11'h555,8'hAA,4'd7},
    {2'd0,11'h2AA,8'h55,4'd7},
    {2'd0,11'h000,8'h30,4'd7},{2'd0,11'h400,8'h30,4'd7},
    {2'd2,11'h000,8'h00,4'd7},
    {2'd1,11'h000,8'hFF,4'd7},{2'd1,11'h400,8'hFF,4'd7},
    {2'd1,11'h200,8'h33,4'd7},{2'd1,11'h600,8'h78,4'd7},
    {2'd0,11'h555,8'hAA,4'd6},{2'd0,11'h2AA,8'h55,4'd6},          // R6 whole-array erase
    {2'd0,11'h555,8'h80,4'd6},{2'd0,11'h555,8'hAA,4'd6},
    {2'd0,11'h2AA,8'h55,4'd6},{2'd0,11'h555,8'h10,4'd6},
    {2'd0,11'h555,8'hAA,4'd6},{2'd0,11'h2AA,8'h55,4'd6},          // R6 ignored during erase
    {2'd0,11'h555,8'hA0,4'd6},{2'd0,11'h300,8'h00,4'd6},
    {2'd2,11'h000,8'h00,4'd6},
    {2'd1,11'h200,8'hFF,4'd6},{2'd1,11'h300,8'hFF,4'd6},{2'd1,11'h600,8'hFF,4'd6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (busy) check(req, 8'h01, 8'h00);
  endtask

  task automatic unlock5();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, s1, s2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 busy after reset", {7'b0, busy}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]    op;
      logic [AW-1:0] va;
      logic [7:0]    vd;
      string         tag;
      op  = VEC[i][24:23];
      va  = VEC[i][22:12];
      vd  = VEC[i][11:4];
      tag = $sformatf("R%0d vector %0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr(va, vd);
        2'd1: begin rd(va, d); check(tag, d, vd); end
        default: wait_idle(tag);
      endcase
    end

    // R10 and R9: status during a program of 35h
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h010, 8'h35);
    rd(11'h010, s1);
    rd(11'h010, s2);
    check("R10 polling bit7 during program", {7'b0, s1[7]}, 8'h01);
    check("R11 error bit clear on good program", {7'b0, s1[5]}, 8'h00);
    check("R9 toggle bit flips", {7'b0, s1[6] ^ s2[6]}, 8'h01);
    wait_idle("R1");
    rd(11'h010, d);
    check("R1 program 35h", d, 8'h35);

    // R11: 3Fh over 35h sets bits that are 0
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h010, 8'h3F);
    repeat (PGM + 4) @(negedge clk);
    check("R11 busy held after failure", {7'b0, busy}, 8'h01);
    rd(11'h010, s1);
    check("R11 error bit set", {7'b0, s1[5]}, 8'h01);
    wr(11'h000, 8'hF0);
    @(negedge clk);
    check("R11 busy released by F0h", {7'b0, busy}, 8'h00);
    rd(11'h010, d);
    check("R11 byte unchanged", d, 8'h35);

    // R8 and R7: window bit and restart
    unlock5();
    wr(11'h010, 8'h30);
    rd(11'h000, s1);
    check("R8 bit3 low in window", {7'b0, s1[3]}, 8'h00);
    repeat (WIN - 10) @(negedge clk);
    wr(11'h200, 8'h30);
    repeat (WIN - 10) @(negedge clk);
    rd(11'h000, s1);
    check("R7 window restarted", {7'b0, s1[3]}, 8'h00);
    repeat (20) @(negedge clk);
    rd(11'h000, s1);
    check("R8 bit3 high while erasing", {7'b0, s1[3]}, 8'h01);
    check("R10 polling bit7 low during erase", {7'b0, s1[7]}, 8'h00);
    wait_idle("R7");
    rd(11'h010, d);
    check("R7 first sector erased", d, 8'hFF);

    summary();
    $finish;
  end
endmodule